// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a parameterized set of level-sensitive peripheral lines and a small group of software-settable sources. Each source carries a programmable 4-bit priority. Combinational arbitration picks the pending source with the highest priority; among equal priorities the lowest source index wins. The winner's index is its unique 9-bit vector. The controller compares the winning priority with the processor's current priority and offers the vector only when the winner is strictly higher.

The processor takes an interrupt through a valid/ready handshake. `irq_valid` means a request is offered. `irq_vector` and `irq_prio` describe it. A transfer happens on a rising edge where `irq_valid` and `irq_ready` are both high. This is not a held stream. While `irq_ready` is low, the offered vector may change if a higher source arrives, and the offer may be withdrawn if its source drops or the current priority is raised. The handshake takes whatever is offered in that cycle.

On a transfer, the current priority is pushed onto a 16-entry LIFO and replaced by the taken source's priority. An end-of-interrupt write pops the LIFO. Software may also write the current priority directly, so that a task touching a shared resource can fence out every interrupt at or below a chosen level. The total source count is rounded up to a multiple of four, and the padding sources are never pending.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid` is 0, `cur_prio` is 0, `ack_vector` is 0, every source priority is 0, all software sources are clear and the LIFO is empty.
- R2: A write to address A with A below the rounded source count sets that source's priority to `cfg_wdata[3:0]`. A pending source whose priority is 0 never produces a request.
- R3: `irq_valid` is 1 exactly when some pending source has a priority strictly above `cur_prio`. `irq_prio` then shows the highest such priority.
- R4: Among pending sources of the winning priority, the lowest index wins. `irq_vector` equals that source index, so every vector lies below the rounded source count.
- R5: Each peripheral line `irq_src[i]` is source i. A change driven on it between edges reaches `irq_valid`/`irq_vector` after the second following rising edge, through a two-flop synchronizer. It is level-sensitive, both rising and falling.
- R6: Software source k is source NUM_PERIPH+k. A write to 0x82 sets every software source whose data bit k is 1. A write to 0x83 clears every one whose bit is 1. Data bits at 0 leave their sources unchanged. The effect is visible right after the write edge.
- R7: On a handshake edge, `ack_vector` takes `irq_vector`, the old `cur_prio` is pushed onto the LIFO, and `cur_prio` takes `irq_prio`.
- R8: A write to 0x81 (end of interrupt) pops the LIFO into `cur_prio`, so nested interrupts unwind in reverse order. A pop on an empty LIFO sets `cur_prio` to 0.
- R9: A write to 0x80 sets `cur_prio` to `cfg_wdata[3:0]` without touching the LIFO. Requests at or below that level are masked.
- R10: When a handshake and a write to 0x80 or 0x81 fall on the same edge, the handshake takes effect and the write is dropped.
- R11: `irq_ready` while `irq_valid` is 0 changes neither `cur_prio` nor `ack_vector`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | NUM_PERIPH | Level-sensitive peripheral request lines |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register write address |
| cfg_wdata | input | DATA_W | Register write data |
| irq_valid | output | 1 | An interrupt is offered to the processor |
| irq_ready | input | 1 | Processor takes the offered interrupt |
| irq_vector | output | 9 | Vector of the offered source |
| irq_prio | output | 4 | Priority of the offered source |
| cur_prio | output | 4 | Current processor priority |
| ack_vector | output | 9 | Vector of the last interrupt taken |

## Verification
Arbitration is tried with several mixes of pending sources. Equal-priority peripheral pairs show whether the tie order is by index. A later, higher source arriving while a lower one waits separates priority ordering from arrival order. Software and peripheral sources competing separate the two request paths. A chain of fifteen nested interrupts at rising priorities, unwound by end-of-interrupt writes, shows whether the LIFO returns levels in reverse order. Directly written current priorities at, just below and above a pending level tell strict masking from inclusive masking. Same-edge handshake-and-write stimulus shows which update wins.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 9;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [VEC_W-1:0]  vec_t;

  // update applied to the current priority on an edge
  typedef enum logic [1:0] {
    CP_HOLD,
    CP_TAKE,
    CP_POP,
    CP_LOAD
  } cp_op_e;

  function automatic int round_up4(int n);
    return ((n + 3) / 4) * 4;
  endfunction
endpackage

// File: rtl/prio_irq_inputs.sv
module prio_irq_inputs
  import prio_irq_pkg::*;
#(
  parameter int NUM_PERIPH = 28,
  parameter int NUM_SW     = 4,
  parameter int SRC_TOTAL  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] periph_in,
  input  logic                  sw_set_we,
  input  logic                  sw_clr_we,
  input  logic [NUM_SW-1:0]     sw_bits,
  output logic [SRC_TOTAL-1:0]  pending
);
  logic [NUM_PERIPH-1:0] meta_q, sync_q;
  logic [NUM_SW-1:0]     sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= periph_in;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sw_q <= '0;
    else if (sw_set_we) sw_q <= sw_q | sw_bits;
    else if (sw_clr_we) sw_q <= sw_q & ~sw_bits;
  end

  generate
    for (genvar i = 0; i < SRC_TOTAL; i++) begin : g_src
      if (i < NUM_PERIPH) begin : g_periph
        assign pending[i] = sync_q[i];
      end else if (i < NUM_PERIPH + NUM_SW) begin : g_soft
        assign pending[i] = sw_q[i-NUM_PERIPH];
      end else begin : g_pad
        assign pending[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/prio_irq_prio_table.sv
module prio_irq_prio_table
  import prio_irq_pkg::*;
#(
  parameter int SRC_TOTAL = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  prio_t                   wprio,
  output prio_t [SRC_TOTAL-1:0]   prio_tab
);
  generate
    for (genvar i = 0; i < SRC_TOTAL; i++) begin : g_ent
      prio_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= '0;
        else if (we && addr == ADDR_W'(i))   q <= wprio;
      end
      assign prio_tab[i] = q;
    end
  endgenerate
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int SRC_TOTAL = 32
) (
  input  logic [SRC_TOTAL-1:0]  pend,
  input  prio_t [SRC_TOTAL-1:0] prio_tab,
  output prio_t                 win_prio,
  output vec_t                  win_vec
);
  localparam int GROUPS = SRC_TOTAL / 4;

  prio_t [GROUPS-1:0] g_prio;
  vec_t  [GROUPS-1:0] g_vec;

  // first stage: winner inside each group of four
  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      prio_t lp;
      vec_t  lv;
      always_comb begin
        lp = '0;
        lv = '0;
        for (int k = 3; k >= 0; k--) begin
          if (pend[4*g+k] && prio_tab[4*g+k] != '0 && prio_tab[4*g+k] >= lp) begin
            lp = prio_tab[4*g+k];
            lv = VEC_W'(4*g+k);
          end
        end
      end
      assign g_prio[g] = lp;
      assign g_vec[g]  = lv;
    end
  endgenerate

  // second stage: across groups, earlier group wins a tie
  always_comb begin
    win_prio = '0;
    win_vec  = '0;
    for (int g = GROUPS-1; g >= 0; g--) begin
      if (g_prio[g] != '0 && g_prio[g] >= win_prio) begin
        win_prio = g_prio[g];
        win_vec  = g_vec[g];
      end
    end
  end
endmodule

// File: rtl/prio_irq_lifo.sv
module prio_irq_lifo
  import prio_irq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  logic  pop,
  input  prio_t din,
  output prio_t top
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  prio_t            mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             empty, full;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push && !full) mem[PTR_W'(cnt)] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (push && !full)    cnt <= cnt + CNT_W'(1);
    else if (pop && !empty)    cnt <= cnt - CNT_W'(1);
  end

  assign top = empty ? '0 : mem[PTR_W'(cnt - CNT_W'(1))];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_PERIPH  = 28,
  parameter int NUM_SW      = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int STACK_DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] irq_src,
  input  logic                  cfg_wr_en,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic                  irq_valid,
  input  logic                  irq_ready,
  output logic [VEC_W-1:0]      irq_vector,
  output logic [PRIO_W-1:0]     irq_prio,
  output logic [PRIO_W-1:0]     cur_prio,
  output logic [VEC_W-1:0]      ack_vector
);
  localparam int SRC_TOTAL = round_up4(NUM_PERIPH + NUM_SW);
  localparam int CTRL_BASE = 2 ** (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] A_CUR = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(CTRL_BASE + 1);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(CTRL_BASE + 2);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CTRL_BASE + 3);

  logic [SRC_TOTAL-1:0]  pending;
  prio_t [SRC_TOTAL-1:0] prio_tab;
  prio_t                 win_prio, lifo_top, cur_q;
  vec_t                  win_vec, ack_q;
  logic                  wr_prio, wr_cur, wr_eoi, wr_set, wr_clr, take;
  cp_op_e                op;
  logic                  unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  assign wr_prio = cfg_wr_en && (cfg_addr < ADDR_W'(SRC_TOTAL));
  assign wr_cur  = cfg_wr_en && (cfg_addr == A_CUR);
  assign wr_eoi  = cfg_wr_en && (cfg_addr == A_EOI);
  assign wr_set  = cfg_wr_en && (cfg_addr == A_SET);
  assign wr_clr  = cfg_wr_en && (cfg_addr == A_CLR);

  prio_irq_inputs #(
    .NUM_PERIPH(NUM_PERIPH), .NUM_SW(NUM_SW), .SRC_TOTAL(SRC_TOTAL)
  ) u_inputs (
    .clk(clk), .rst_n(rst_n), .periph_in(irq_src),
    .sw_set_we(wr_set), .sw_clr_we(wr_clr),
    .sw_bits(cfg_wdata[NUM_SW-1:0]), .pending(pending)
  );

  prio_irq_prio_table #(.SRC_TOTAL(SRC_TOTAL), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(wr_prio), .addr(cfg_addr),
    .wprio(cfg_wdata[PRIO_W-1:0]), .prio_tab(prio_tab)
  );

  prio_irq_arbiter #(.SRC_TOTAL(SRC_TOTAL)) u_arb (
    .pend(pending), .prio_tab(prio_tab), .win_prio(win_prio), .win_vec(win_vec)
  );

  assign irq_valid  = (win_prio > cur_q);
  assign irq_vector = win_vec;
  assign irq_prio   = win_prio;
  assign take       = irq_valid && irq_ready;

  // handshake outranks end-of-interrupt, which outranks a direct load
  always_comb begin
    if (take)        op = CP_TAKE;
    else if (wr_eoi) op = CP_POP;
    else if (wr_cur) op = CP_LOAD;
    else             op = CP_HOLD;
  end

  prio_irq_lifo #(.DEPTH(STACK_DEPTH)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push(op == CP_TAKE), .pop(op == CP_POP),
    .din(cur_q), .top(lifo_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else begin
      case (op)
        CP_TAKE: cur_q <= win_prio;
        CP_POP:  cur_q <= lifo_top;
        CP_LOAD: cur_q <= cfg_wdata[PRIO_W-1:0];
        default: cur_q <= cur_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ack_q <= '0;
    else if (take) ack_q <= win_vec;
  end

  assign cur_prio   = cur_q;
  assign ack_vector = ack_q;
endmodule

// File: rtl/prio_irq_ctrl_sva.sv
module prio_irq_ctrl_sva #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int SRC_TOTAL = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic [8:0]        irq_vector,
  input logic [3:0]        irq_prio,
  input logic [3:0]        cur_prio,
  input logic [8:0]        ack_vector
);
  localparam int CTRL_BASE = 2 ** (ADDR_W - 1);
  logic take, wr_cur, wr_eoi;
  assign take   = irq_valid && irq_ready;
  assign wr_cur = cfg_wr_en && cfg_addr == ADDR_W'(CTRL_BASE);
  assign wr_eoi = cfg_wr_en && cfg_addr == ADDR_W'(CTRL_BASE + 1);

  a_r2_zero_never_offered: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_prio != 4'd0);

  a_r4_vector_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector < 9'(SRC_TOTAL));

  a_r7_take_loads_prio: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cur_prio == $past(irq_prio));

  a_r7_take_latches_vector: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ack_vector == $past(irq_vector));

  a_r9_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cur && !take) |=> cur_prio == $past(cfg_wdata[3:0]));

  a_r10_take_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (wr_cur || wr_eoi)) |=> cur_prio == $past(irq_prio));

  a_r11_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ready && !irq_valid && !cfg_wr_en) |=> ($stable(cur_prio) && $stable(ack_vector)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_TOTAL(SRC_TOTAL)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vector(irq_vector), .irq_prio(irq_prio), .cur_prio(cur_prio),
  .ack_vector(ack_vector)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int A_CUR = 8'h80, A_EOI = 8'h81, A_SET = 8'h82, A_CLR = 8'h83;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [27:0] irq_src = '0;
  logic        cfg_wr_en = 1'b0, irq_ready = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        irq_valid;
  logic [8:0]  irq_vector, ack_vector;
  logic [3:0]  irq_prio, cur_prio;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector), .irq_prio(irq_prio),
    .cur_prio(cur_prio), .ack_vector(ack_vector)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  typedef struct { int vec; int prio; int cyc; } exp_t;
  exp_t sb_q[$];

  always @(posedge clk) cyc++;

  task automatic check_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 8'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // driver: takes the offered interrupt and queues what must result
  task automatic take(int ev, int ep);
    exp_t e;
    @(negedge clk);
    check_eq("R7 offer present before take", int'(irq_valid), 1);
    e.vec = ev; e.prio = ep; e.cyc = cyc;
    sb_q.push_back(e);
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
  endtask

  // monitor: compares results once the handshake edge has passed
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        check_eq("R7 ack_vector after take", int'(ack_vector), e.vec);
        check_eq("R7 cur_prio after take", int'(cur_prio), e.prio);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 irq_valid", int'(irq_valid), 0);
    check_eq("R1 cur_prio", int'(cur_prio), 0);
    check_eq("R1 ack_vector", int'(ack_vector), 0);
    // R2: pending with reset priority 0 never requests
    irq_src[5] = 1'b1; irq_src[9] = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R2 zero priority silent", int'(irq_valid), 0);
    wr(5, 3); wr(9, 3);
    check_eq("R3 valid above cur", int'(irq_valid), 1);
    check_eq("R3 irq_prio", int'(irq_prio), 3);
    check_eq("R4 tie lowest index", int'(irq_vector), 5);
    // R5 synchronizer latency on rise
    wr(2, 7);
    @(negedge clk); irq_src[2] = 1'b1;
    @(negedge clk);
    check_eq("R5 one edge not yet", int'(irq_vector), 5);
    @(negedge clk);
    check_eq("R5 two edges higher wins", int'(irq_vector), 2);
    take(2, 7);
    @(negedge clk);
    check_eq("R3 equal level masked", int'(irq_valid), 0);
    // R6 software sources
    wr(29, 12);
    wr(A_SET, 4'b0010);
    check_eq("R6 sw set valid", int'(irq_valid), 1);
    check_eq("R6 sw set vector", int'(irq_vector), 29);
    wr(A_CLR, 4'b1101);
    check_eq("R6 zero bits ignored", int'(irq_vector), 29);
    take(29, 12);
    wr(A_EOI, 0);
    check_eq("R8 pop to 7", int'(cur_prio), 7);
    check_eq("R3 sw re-offered", int'(irq_vector), 29);
    wr(A_CLR, 4'b0010);
    check_eq("R6 sw clear", int'(irq_valid), 0);
    wr(A_EOI, 0);
    check_eq("R8 pop to 0", int'(cur_prio), 0);
    check_eq("R3 vector after pop", int'(irq_vector), 2);
    // R5 fall
    @(negedge clk); irq_src[2] = 1'b0;
    @(negedge clk);
    check_eq("R5 fall one edge", int'(irq_vector), 2);
    @(negedge clk);
    check_eq("R5 fall two edges", int'(irq_vector), 5);
    // R9 direct priority load
    wr(A_CUR, 2);
    check_eq("R9 below level offered", int'(irq_valid), 1);
    wr(A_CUR, 3);
    check_eq("R9 at level masked", int'(irq_valid), 0);
    wr(A_CUR, 9); wr(A_EOI, 0);
    check_eq("R8 empty pop gives 0", int'(cur_prio), 0);
    // R10 take with end-of-interrupt on the same edge
    begin
      exp_t e;
      @(negedge clk);
      e.vec = 5; e.prio = 3; e.cyc = cyc; sb_q.push_back(e);
      irq_ready = 1'b1; cfg_wr_en = 1'b1; cfg_addr = 8'(A_EOI);
      @(negedge clk);
      irq_ready = 1'b0; cfg_wr_en = 1'b0;
      check_eq("R10 eoi dropped", int'(cur_prio), 3);
      wr(A_EOI, 0);
      @(negedge clk);
      e.cyc = cyc; sb_q.push_back(e);
      irq_ready = 1'b1; cfg_wr_en = 1'b1; cfg_addr = 8'(A_CUR); cfg_wdata = 16'd12;
      @(negedge clk);
      irq_ready = 1'b0; cfg_wr_en = 1'b0;
      check_eq("R10 load dropped", int'(cur_prio), 3);
      wr(A_EOI, 0);
    end
    // R11 ready with nothing offered
    wr(A_CUR, 15);
    @(negedge clk); irq_ready = 1'b1;
    @(negedge clk); irq_ready = 1'b0;
    check_eq("R11 cur_prio kept", int'(cur_prio), 15);
    check_eq("R11 ack_vector kept", int'(ack_vector), 5);
    wr(A_EOI, 0);
    // R8 fifteen nested levels
    irq_src[5] = 1'b0; irq_src[9] = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R3 all quiet", int'(irq_valid), 0);
    for (int p = 1; p <= 15; p++) begin
      wr(9 + p, p);
      irq_src[9 + p] = 1'b1;
      repeat (2) @(negedge clk);
      check_eq("R4 nested vector", int'(irq_vector), 9 + p);
      take(9 + p, p);
    end
    @(negedge clk);
    check_eq("R7 deepest level", int'(cur_prio), 15);
    for (int p = 14; p >= 0; p--) begin
      wr(A_EOI, 0);
      check_eq("R8 unwind order", int'(cur_prio), p);
    end
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule